// File: doc/BRIEF.md
# Masked Gather Engine with Ordered Fault Reporting

This block loads up to eight 32-bit elements into a destination vector. Each element comes from its own address: a shared base plus four times that lane's index. A per-lane pending mask says which lanes still have to be loaded. The engine works through the pending lanes with one outstanding memory request at a time. When a lane loads cleanly, the engine writes its data into the lane and clears the lane's pending bit.

The returned mask is the record of progress. A run can stop early for two reasons. A memory response may carry a fault flag, or an interrupt request may arrive between responses. In either case the caller keeps the returned data and mask, deals with the cause, and starts again with the returned mask as the new input. Lanes that are already loaded are never fetched again.

A fault is always reported on the lowest-numbered lane that is still pending. Before the engine reports a fault, it first finishes every other pending lane that it can load. Each restart therefore clears at least the reported lane, so a sequence of restarts always reaches completion. A new full gather needs a fresh all-ones mask from the caller.

Top module: `mgather_top`

## Requirements
- R1: A lane whose mask bit is 0 at start is never requested from memory, and its data output keeps the destination value supplied at start.
- R2: When a lane's response arrives without fault, the response data is written into that lane and the lane's mask bit becomes 0 in the next cycle.
- R3: The request address for lane i is base + 4*index[i], computed modulo 2^32.
- R4: A fault pulse reports, on the fault lane output, the lowest-numbered lane whose mask bit is still 1. That lane's bit is 1 and every lower bit is 0.
- R5: Before a fault is reported, every pending lane that does not fault is loaded. At the fault pulse, the mask output equals the input mask ANDed with the set of faulting lanes.
- R6: A run started with a returned mask issues exactly one request per set mask bit. When at least one pending lane does not fault, the returned mask has fewer set bits than the input mask.
- R7: The interrupt input is checked only while no request is outstanding and only after at least one response in the current run. When it is taken, the block stops with an interrupt pulse and leaves the remaining lanes set in the mask.
- R8: When the mask reaches all zeros, the block gives a done pulse. A start with an all-zero mask gives a done pulse with no memory request.
- R9: Done, fault and interrupt pulses are mutually exclusive and each lasts exactly one cycle. A request stays asserted with a stable address until it is granted. After reset the block is idle with all outputs low.
- R10: With the default setting, lanes are issued from the highest-numbered pending lane down to the lowest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a run; accepted only while idle |
| base_i | input | 32 | Base address |
| index_i | input | 256 | Eight 32-bit lane indices, lane 0 in the low bits |
| mask_i | input | 8 | Pending lanes for this run |
| dest_i | input | 256 | Prior destination contents, lane 0 in the low bits |
| irq_i | input | 1 | Interrupt request |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Request address |
| mem_gnt_i | input | 1 | Request accepted this cycle |
| mem_rsp_valid_i | input | 1 | Response valid |
| mem_rsp_data_i | input | 32 | Response data |
| mem_rsp_fault_i | input | 1 | Response carries a fault |
| data_o | output | 256 | Gathered destination vector |
| mask_o | output | 8 | Lanes still pending |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | One-cycle fault pulse |
| fault_lane_o | output | 3 | Lane reported with the fault |
| intr_o | output | 1 | One-cycle interrupted pulse |

## Verification
The bench builds the block with its defaults: eight lanes and descending issue order. At that size every one of the 256 input masks can be swept. Each mask gets its own fault pattern and a base that makes some addresses wrap past 2^32. The bench restarts with the returned mask until the gather completes, and after every run it checks the fault lane, the mask, the request count and the progress. Descending order makes the interrupt outcome predictable: exactly the highest pending lane is consumed before the stop, and a single-lane mask finishes with done instead.

// File: rtl/mgather_pkg.sv
package mgather_pkg;

  typedef enum logic [1:0] {
    G_IDLE = 2'd0,
    G_PICK = 2'd1,
    G_REQ  = 2'd2,
    G_WAIT = 2'd3
  } gstate_e;

  // Element address: base plus index scaled by the 4-byte element size, 32-bit wrap.
  function automatic logic [31:0] lane_addr(input logic [31:0] base, input logic [31:0] idx);
    return base + {idx[29:0], 2'b00};
  endfunction

endpackage

// File: rtl/mgather_pick.sv
module mgather_pick #(
  parameter int LANES   = 8,
  parameter int LW      = 3,
  parameter bit DESCEND = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] cand_i,
  output logic             any_o,
  output logic [LW-1:0]    lane_o
);

  assign any_o = |cand_i;

  generate
    if (DESCEND) begin : g_desc
      // Later iterations win: highest set lane is chosen.
      always_comb begin
        lane_o = '0;
        for (int i = 0; i < LANES; i++) begin
          if (cand_i[i]) lane_o = LW'(i);
        end
      end
    end else begin : g_asc
      always_comb begin
        lane_o = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
          if (cand_i[i]) lane_o = LW'(i);
        end
      end
    end
  endgenerate

  // R10: the chosen lane is always a candidate.
  p_pick_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> cand_i[lane_o]);

endmodule

// File: rtl/mgather_lanes.sv
module mgather_lanes #(
  parameter int LANES = 8,
  parameter int LW    = 3,
  parameter int DW    = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_i,
  input  logic [LANES-1:0][DW-1:0]   dest_i,
  input  logic [LANES-1:0]           mask_i,
  input  logic                       wr_en_i,
  input  logic [LW-1:0]              wr_lane_i,
  input  logic [DW-1:0]              wr_data_i,
  input  logic                       wr_fault_i,
  output logic [LANES-1:0][DW-1:0]   data_o,
  output logic [LANES-1:0]           mask_o,
  output logic [LANES-1:0]           flt_o
);

  logic [LANES-1:0][DW-1:0] data_q;
  logic [LANES-1:0]         mask_q;
  logic [LANES-1:0]         flt_q;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic hit;
      assign hit = wr_en_i && (wr_lane_i == LW'(g));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          data_q[g] <= '0;
          mask_q[g] <= 1'b0;
          flt_q[g]  <= 1'b0;
        end else if (load_i) begin
          data_q[g] <= dest_i[g];
          mask_q[g] <= mask_i[g];
          flt_q[g]  <= 1'b0;
        end else if (hit) begin
          if (wr_fault_i) begin
            flt_q[g] <= 1'b1;
          end else begin
            data_q[g] <= wr_data_i;
            mask_q[g] <= 1'b0;
          end
        end
      end
    end
  endgenerate

  assign data_o = data_q;
  assign mask_o = mask_q;
  assign flt_o  = flt_q;

  // R1: a response only ever lands on a lane that was still pending.
  p_write_pending_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |-> mask_q[wr_lane_i]);

  // R2: a clean response clears the written lane's bit.
  p_clear_on_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_fault_i && !load_i) |=> !mask_q[$past(wr_lane_i)]);

  // R5: a faulting lane keeps its pending bit.
  p_keep_on_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_fault_i && !load_i) |=> mask_q[$past(wr_lane_i)]);

endmodule

// File: rtl/mgather_ctrl.sv
module mgather_ctrl
  import mgather_pkg::*;
#(
  parameter int LANES = 8,
  parameter int LW    = 3,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [31:0]              base_i,
  input  logic [LANES-1:0][31:0]   index_i,
  input  logic                     irq_i,
  input  logic                     cand_any_i,
  input  logic [LW-1:0]            pick_lane_i,
  input  logic [LANES-1:0]         flt_i,
  output logic                     mem_req_o,
  output logic [31:0]              mem_addr_o,
  input  logic                     mem_gnt_i,
  input  logic                     mem_rsp_valid_i,
  input  logic [DW-1:0]            mem_rsp_data_i,
  input  logic                     mem_rsp_fault_i,
  output logic                     load_o,
  output logic                     wr_en_o,
  output logic [LW-1:0]            wr_lane_o,
  output logic [DW-1:0]            wr_data_o,
  output logic                     wr_fault_o,
  output logic                     done_o,
  output logic                     fault_o,
  output logic [LW-1:0]            fault_lane_o,
  output logic                     intr_o
);

  gstate_e                 st_q;
  logic [31:0]             base_q;
  logic [LANES-1:0][31:0]  idx_q;
  logic [LW-1:0]           lane_q;
  logic [31:0]             addr_q;
  logic                    got_q;
  logic                    done_q, fault_q, intr_q;
  logic [LW-1:0]           flane_q;
  logic [LW-1:0]           low_flt;

  // Named internal events for the assertions.
  logic ev_finish, ev_take_irq, ev_issue, ev_grant, ev_resp;

  always_comb begin
    low_flt = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (flt_i[i]) low_flt = LW'(i);
    end
  end

  assign ev_finish   = (st_q == G_PICK) && !cand_any_i;
  assign ev_take_irq = (st_q == G_PICK) && cand_any_i && irq_i && got_q;
  assign ev_issue    = (st_q == G_PICK) && cand_any_i && !(irq_i && got_q);
  assign ev_grant    = (st_q == G_REQ) && mem_gnt_i;
  assign ev_resp     = (st_q == G_WAIT) && mem_rsp_valid_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= G_IDLE;
      base_q  <= '0;
      idx_q   <= '0;
      lane_q  <= '0;
      addr_q  <= '0;
      got_q   <= 1'b0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      intr_q  <= 1'b0;
      flane_q <= '0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      intr_q  <= 1'b0;
      unique case (st_q)
        G_IDLE: begin
          if (start_i) begin
            base_q <= base_i;
            idx_q  <= index_i;
            got_q  <= 1'b0;
            st_q   <= G_PICK;
          end
        end
        G_PICK: begin
          if (ev_finish) begin
            if (|flt_i) begin
              fault_q <= 1'b1;
              flane_q <= low_flt;
            end else begin
              done_q <= 1'b1;
            end
            st_q <= G_IDLE;
          end else if (ev_take_irq) begin
            intr_q <= 1'b1;
            st_q   <= G_IDLE;
          end else begin
            lane_q <= pick_lane_i;
            addr_q <= lane_addr(base_q, idx_q[pick_lane_i]);
            st_q   <= G_REQ;
          end
        end
        G_REQ: begin
          if (mem_gnt_i) st_q <= G_WAIT;
        end
        G_WAIT: begin
          if (mem_rsp_valid_i) begin
            got_q <= 1'b1;
            st_q  <= G_PICK;
          end
        end
        default: st_q <= G_IDLE;
      endcase
    end
  end

  assign load_o       = (st_q == G_IDLE) && start_i;
  assign mem_req_o    = (st_q == G_REQ);
  assign mem_addr_o   = addr_q;
  assign wr_en_o      = ev_resp;
  assign wr_lane_o    = lane_q;
  assign wr_data_o    = mem_rsp_data_i;
  assign wr_fault_o   = mem_rsp_fault_i;
  assign done_o       = done_q;
  assign fault_o      = fault_q;
  assign fault_lane_o = flane_q;
  assign intr_o       = intr_q;

  // R7: the interrupt is never taken while a request is outstanding.
  p_irq_between_r7: assert property (@(posedge clk) disable iff (!rst_n)
    intr_o |-> $past(st_q == G_PICK) && got_q);

  // R9: the request is held with a stable address until granted.
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R9: after a grant the block waits for the response and issues nothing new.
  p_one_outstanding_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_grant |=> !mem_req_o);

endmodule

// File: rtl/mgather_top.sv
module mgather_top #(
  parameter int LANES   = 8,
  parameter int DW      = 32,
  parameter bit DESCEND = 1'b1,
  localparam int LW     = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [31:0]           base_i,
  input  logic [LANES*32-1:0]   index_i,
  input  logic [LANES-1:0]      mask_i,
  input  logic [LANES*DW-1:0]   dest_i,
  input  logic                  irq_i,
  output logic                  mem_req_o,
  output logic [31:0]           mem_addr_o,
  input  logic                  mem_gnt_i,
  input  logic                  mem_rsp_valid_i,
  input  logic [DW-1:0]         mem_rsp_data_i,
  input  logic                  mem_rsp_fault_i,
  output logic [LANES*DW-1:0]   data_o,
  output logic [LANES-1:0]      mask_o,
  output logic                  done_o,
  output logic                  fault_o,
  output logic [LW-1:0]         fault_lane_o,
  output logic                  intr_o
);

  logic [LANES-1:0][31:0]  idx_w;
  logic [LANES-1:0][DW-1:0] dest_w, data_w;
  logic [LANES-1:0]        mask_w, flt_w, cand_w;
  logic                    cand_any;
  logic [LW-1:0]           pick_lane;
  logic                    load_w, wr_en, wr_fault;
  logic [LW-1:0]           wr_lane;
  logic [DW-1:0]           wr_data;

  assign idx_w  = index_i;
  assign dest_w = dest_i;
  assign cand_w = mask_w & ~flt_w;

  mgather_lanes #(.LANES(LANES), .LW(LW), .DW(DW)) u_lanes (
    .clk(clk), .rst_n(rst_n), .load_i(load_w), .dest_i(dest_w), .mask_i(mask_i),
    .wr_en_i(wr_en), .wr_lane_i(wr_lane), .wr_data_i(wr_data), .wr_fault_i(wr_fault),
    .data_o(data_w), .mask_o(mask_w), .flt_o(flt_w)
  );

  mgather_pick #(.LANES(LANES), .LW(LW), .DESCEND(DESCEND)) u_pick (
    .clk(clk), .rst_n(rst_n), .cand_i(cand_w), .any_o(cand_any), .lane_o(pick_lane)
  );

  mgather_ctrl #(.LANES(LANES), .LW(LW), .DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i), .index_i(idx_w),
    .irq_i(irq_i), .cand_any_i(cand_any), .pick_lane_i(pick_lane), .flt_i(flt_w),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_gnt_i(mem_gnt_i),
    .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_data_i(mem_rsp_data_i),
    .mem_rsp_fault_i(mem_rsp_fault_i), .load_o(load_w), .wr_en_o(wr_en),
    .wr_lane_o(wr_lane), .wr_data_o(wr_data), .wr_fault_o(wr_fault),
    .done_o(done_o), .fault_o(fault_o), .fault_lane_o(fault_lane_o), .intr_o(intr_o)
  );

  assign data_o = data_w;
  assign mask_o = mask_w;

  logic [LANES-1:0] below_flane;
  assign below_flane = (LANES'(1) << fault_lane_o) - LANES'(1);

  // R9: completion, fault and interrupt never coincide.
  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, fault_o, intr_o}));

  // R9: every pulse lasts a single cycle.
  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || fault_o || intr_o) |=> !(done_o || fault_o || intr_o));

  // R8: done only with nothing pending.
  p_done_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (mask_o == '0));

  // R4: the reported lane is the lowest pending lane.
  p_fault_lowest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (mask_o[fault_lane_o] && ((mask_o & below_flane) == '0)));

endmodule

// File: tb/mgather_top_tb.sv
`timescale 1ns/1ps
module mgather_top_tb_top;
  localparam int L = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                rst_n, start, irq;
  logic [31:0]         base;
  logic [L-1:0][31:0]  idx;
  logic [L-1:0]        mask_in;
  logic [L-1:0][31:0]  dest;
  logic                mem_req, gnt, rsp_v, rsp_f;
  logic [31:0]         mem_addr, rsp_d;
  logic [L*32-1:0]     data_o;
  logic [L-1:0]        mask_o;
  logic                done_o, fault_o, intr_o;
  logic [2:0]          flane;

  int checks = 0, errors = 0, cyc = 0, reqs = 0, bad_reqs = 0;
  logic [L-1:0] fmask, run_mask;
  logic hit_v;

  mgather_top dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .base_i(base), .index_i(idx),
    .mask_i(mask_in), .dest_i(dest), .irq_i(irq), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_gnt_i(gnt), .mem_rsp_valid_i(rsp_v),
    .mem_rsp_data_i(rsp_d), .mem_rsp_fault_i(rsp_f), .data_o(data_o),
    .mask_o(mask_o), .done_o(done_o), .fault_o(fault_o), .fault_lane_o(flane),
    .intr_o(intr_o)
  );

  function automatic logic [31:0] ea(input int l);
    logic [31:0] p;
    p = idx[l] * 32'd4;
    return base + p;
  endfunction

  function automatic logic [31:0] memv(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic int pop(input logic [L-1:0] v);
    int n = 0;
    for (int i = 0; i < L; i++) if (v[i]) n++;
    return n;
  endfunction

  function automatic int lowest(input logic [L-1:0] v);
    for (int i = 0; i < L; i++) if (v[i]) return i;
    return 0;
  endfunction

  function automatic int highest(input logic [L-1:0] v);
    for (int i = L - 1; i >= 0; i--) if (v[i]) return i;
    return 0;
  endfunction

  assign gnt = mem_req && ((cyc % 4) != 1);

  // Memory model: one-cycle response, fault by lane address.
  always @(posedge clk) begin
    cyc   <= cyc + 1;
    rsp_v <= 1'b0;
    if (mem_req && gnt) begin
      rsp_v <= 1'b1;
      rsp_d <= memv(mem_addr);
      rsp_f <= 1'b0;
      reqs  <= reqs + 1;
      hit_v = 1'b0;
      for (int l = 0; l < L; l++) begin
        if (run_mask[l] && mem_addr == ea(l)) begin
          hit_v = 1'b1;
          if (fmask[l]) rsp_f <= 1'b1;
        end
      end
      if (!hit_v) bad_reqs <= bad_reqs + 1;
    end
  end

  task automatic check(input bit ok, input string rq, input logic [255:0] act,
                       input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  int r0, b0;
  task automatic run(input logic [L-1:0] m);
    @(negedge clk);
    mask_in  = m;
    run_mask = m;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    r0 = reqs;
    b0 = bad_reqs;
    do @(negedge clk); while (!(done_o || fault_o || intr_o));
  endtask

  // Full gather with restarts; faults are cleared one lane per restart.
  task automatic gather_full(input logic [L-1:0] m, input logic [L-1:0] f);
    logic [L-1:0]       cur;
    logic [L-1:0][31:0] d0, expd;
    bit finished = 0;
    fmask = f;
    d0 = dest;
    cur = m;
    for (int k = 0; k < L + 2 && !finished; k++) begin
      run(cur);
      for (int l = 0; l < L; l++)
        expd[l] = (cur[l] && !fmask[l]) ? memv(ea(l)) : dest[l];
      check(data_o == expd, "R2 lane data", data_o, expd);
      check(reqs - r0 == pop(cur), "R6 one request per pending lane", reqs - r0, pop(cur));
      check(bad_reqs == b0, "R1/R3 request address", bad_reqs - b0, 0);
      if ((cur & fmask) == '0) begin
        check(done_o && !fault_o && !intr_o, "R8 done", {done_o, fault_o, intr_o}, 3'b100);
        check(mask_o == '0, "R8 empty mask", mask_o, 0);
        finished = 1;
      end else begin
        check(fault_o && !done_o, "R4 fault pulse", {done_o, fault_o, intr_o}, 3'b010);
        check(flane == 3'(lowest(cur & fmask)), "R4 lowest lane", flane, lowest(cur & fmask));
        check(mask_o == (cur & fmask), "R5 remaining mask", mask_o, cur & fmask);
        if ((cur & ~fmask) != '0)
          check(pop(mask_o) < pop(cur), "R6 progress", pop(mask_o), pop(cur));
        fmask[lowest(cur & fmask)] = 1'b0;
        dest = data_o;
        cur  = mask_o;
      end
    end
    for (int l = 0; l < L; l++) expd[l] = m[l] ? memv(ea(l)) : d0[l];
    check(finished && data_o == expd, "R1 final data", data_o, expd);
  endtask

  // Interrupt held high from start: one response, then stop (R7, R10).
  task automatic irq_case(input logic [L-1:0] m, input logic [L-1:0] f);
    logic [L-1:0]       em;
    logic [L-1:0][31:0] expd;
    int h;
    fmask = f;
    irq = 1'b1;
    run(m);
    irq = 1'b0;
    h = highest(m);
    em = f[h] ? m : (m & ~(L'(1) << h));
    check(reqs - r0 == 1, "R7 single access before stop", reqs - r0, 1);
    if (em == '0) begin
      check(done_o, "R7 last lane finishes with done", {done_o, intr_o}, 2'b10);
    end else if (pop(m) == 1 && f[h]) begin
      check(fault_o, "R7 lone faulting lane reports fault", {fault_o, intr_o}, 2'b10);
    end else begin
      check(intr_o && !done_o && !fault_o, "R7 interrupt pulse", {done_o, fault_o, intr_o}, 3'b001);
      check(mask_o == em, "R10 highest lane consumed first", mask_o, em);
      for (int l = 0; l < L; l++) expd[l] = (l == h && !f[h]) ? memv(ea(l)) : dest[l];
      check(data_o == expd, "R7 partial data kept", data_o, expd);
    end
    dest = data_o;
    gather_full(mask_o, '0);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: run did not end actual=hang expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; irq = 1'b0; base = '0; idx = '0;
    mask_in = '0; dest = '0; fmask = '0; run_mask = '0;
    repeat (3) @(negedge clk);
    check(!mem_req && !done_o && !fault_o && !intr_o && mask_o == '0,
          "R9 reset idle", {mem_req, done_o, fault_o, intr_o, mask_o}, 0);
    rst_n = 1'b1;

    // Exhaustive mask sweep, per-mask fault pattern and wrapping base.
    for (int m = 0; m < 256; m++) begin
      base = 32'hFFFF_F000 + 32'(m) * 32'h0101_0040;
      for (int l = 0; l < L; l++) begin
        idx[l]  = 32'(l) * 32'h0400_0003 + 32'(m);
        dest[l] = 32'hD000_0000 | (32'(m) << 8) | 32'(l);
      end
      gather_full(8'(m), 8'((m * 29 + 3) ^ 8'h96));
    end

    // Explicit wrap case (R3): base near the top of the address space.
    base = 32'hFFFF_FFF0;
    for (int l = 0; l < L; l++) begin
      idx[l] = 32'h3FFF_FFF8 + 32'(l);
      dest[l] = 32'hBEEF_0000 + 32'(l);
    end
    gather_full(8'hFF, 8'h00);
    check(data_o[31:0] == memv(32'hFFFF_FFD0), "R3 wrapped address lane 0",
          data_o[31:0], memv(32'hFFFF_FFD0));

    // Interrupt cases.
    base = 32'h0000_1000;
    for (int l = 0; l < L; l++) begin
      idx[l] = 32'(l) * 32'd3;
      dest[l] = 32'hCAFE_0000 + 32'(l);
    end
    irq_case(8'hFF, 8'h00);
    irq_case(8'b0101_0110, 8'h00);
    irq_case(8'b0000_0100, 8'h00);
    irq_case(8'b1001_0001, 8'b1000_0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule